// File: doc/BRIEF.md
# Floating-Point Compare Unit with Status Flags and Predicate Masks

This block compares two IEEE-754 operands, either single precision (held in the low 32 bits of each operand port) or double precision (the full 64 bits). It has two modes. In flag mode it returns a six-bit status word that encodes ordering: equal, less, greater or unordered. This mode runs either as a signalling compare or as a quiet compare. In predicate mode it returns an all-ones or all-zeros mask for the "not less than" or "not less or equal" test.

An operand strobe starts a compare. The outputs are registered and show the result one cycle after the strobe. Invalid-operation conditions are detected on each strobe and recorded in a sticky status bit. When the invalid condition is unmasked, the block writes no result. It raises a one-cycle exception request instead, and the previous flags and mask stay in place.

Top module: `fp_cmp_unit`

## Requirements
- R1: A NaN is an operand whose exponent is all ones and whose fraction is nonzero. It is quiet when the top fraction bit is 1 and signalling when that bit is 0. In flag mode, a NaN in either operand writes flags = 6'b000111, with the bit order {OF,SF,AF,ZF,PF,CF} from bit 5 down to bit 0.
- R2: For ordered operands, flag mode writes 6'b000100 when the operands are equal, 6'b000001 when A < B and 6'b000000 when A > B. The bits OF, SF and AF are always 0. +0 and -0 compare equal, and infinities are ordered values.
- R3: A signalling flag compare (quiet_cmp=0) raises invalid for a quiet or a signalling NaN in either operand.
- R4: A quiet flag compare (quiet_cmp=1) raises invalid only for a signalling NaN. A quiet NaN alone writes the unordered flags even when inv_mask=0.
- R5: When invalid is raised and inv_mask=0, no result is written. flags and pmask keep their values, exc_req is 1 and res_wr is 0 in the cycle after the strobe.
- R6: Predicate mode with pred_le=0 tests "not less than" (NLT) and with pred_le=1 tests "not less or equal" (NLE). A true result writes ones in the low 32 bits of pmask for single precision, with the upper 32 bits 0, or all 64 bits for double precision. A false result writes 0. A NaN operand makes the predicate true.
- R7: Both predicates raise invalid for any NaN operand, so with inv_mask=0 the mask result is suppressed.
- R8: is_dbl=1 selects 64-bit interpretation. is_dbl=0 uses only bits 31:0 of each operand, and bits 63:32 are ignored.
- R9: Results, res_wr and exc_req appear one cycle after an in_valid strobe. Without a strobe, flags and pmask hold.
- R10: inv_sticky is set by any invalid condition, masked or not. It clears only on sticky_clr. If a clear and a new invalid arrive in the same cycle, the set wins.
- R11: After reset, flags, pmask, inv_sticky, exc_req and res_wr are all 0.
- R12: Flag mode leaves pmask unchanged, and predicate mode leaves flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| is_dbl | input | 1 | 1 = double precision, 0 = single |
| pred_mode | input | 1 | 0 = flag mode, 1 = predicate mode |
| quiet_cmp | input | 1 | Flag mode: 1 = quiet compare, 0 = signalling |
| pred_le | input | 1 | Predicate: 0 = NLT, 1 = NLE |
| inv_mask | input | 1 | 1 = invalid exception masked |
| sticky_clr | input | 1 | Clears the sticky invalid bit |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| flags | output | 6 | {OF,SF,AF,ZF,PF,CF} |
| pmask | output | 64 | Predicate result mask |
| inv_sticky | output | 1 | Sticky invalid status |
| exc_req | output | 1 | Exception request pulse |
| res_wr | output | 1 | Result-written pulse |

## Verification
Ordered single and double pairs cover less, greater, equal, signed zeros and infinity. These separate the three ordered flag codes and show that -0 is not treated as less than +0. The NaN cases cross quiet and signalling NaNs with the quiet and signalling variants and with both mask settings. Together they show which variant raises invalid, and whether a suppressed write leaves the earlier result in place. Predicate vectors run both predicates on pairs that are less, equal and greater. This separates NLT from NLE at equality. Nonzero upper bits in a single-precision compare, and a clear arriving together with a new invalid, test the precision select and the sticky precedence.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   localparam int FLAG_W = 6;
   localparam logic [FLAG_W-1:0] FL_UNORD = 6'b000111;
   localparam logic [FLAG_W-1:0] FL_EQ    = 6'b000100;
   localparam logic [FLAG_W-1:0] FL_LT    = 6'b000001;
   localparam logic [FLAG_W-1:0] FL_GT    = 6'b000000;

   typedef enum logic {MODE_FLAGS = 1'b0, MODE_PRED = 1'b1} fpc_mode_e;

   typedef struct packed {
      logic nan;
      logic snan;
      logic zero;
      logic sign;
   } fpc_class_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
   import fpc_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] val,
   output fpc_class_t            cls
);
   localparam int W = EXP_W + FRAC_W + 1;

   logic exp_ones, frac_nz;

   always_comb begin
      exp_ones  = &val[W-2:FRAC_W];
      frac_nz   = |val[FRAC_W-1:0];
      cls.nan   = exp_ones & frac_nz;
      cls.snan  = exp_ones & frac_nz & ~val[FRAC_W-1];
      cls.zero  = ~|val[W-2:0];
      cls.sign  = val[W-1];
   end
endmodule

// File: rtl/fpc_order.sv
module fpc_order #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         a_zero,
   input  logic         b_zero,
   output logic         lt,
   output logic         eq
);
   logic mag_lt, mag_eq, sa, sb;

   always_comb begin
      sa     = a[W-1];
      sb     = b[W-1];
      mag_lt = a[W-2:0] < b[W-2:0];
      mag_eq = a[W-2:0] == b[W-2:0];
      if (a_zero && b_zero) begin
         eq = 1'b1;
         lt = 1'b0;
      end else if (sa != sb) begin
         eq = 1'b0;
         lt = sa;
      end else begin
         eq = mag_eq;
         lt = sa ? (!mag_lt && !mag_eq) : mag_lt;
      end
   end
endmodule

// File: rtl/fpc_out_reg.sv
module fpc_out_reg
   import fpc_pkg::*;
#(
   parameter int MASK_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic              pred_mode,
   input  logic              invalid,
   input  logic              suppress,
   input  logic              sticky_clr,
   input  logic [FLAG_W-1:0] flags_nx,
   input  logic [MASK_W-1:0] mask_nx,
   output logic [FLAG_W-1:0] flags,
   output logic [MASK_W-1:0] pmask,
   output logic              inv_sticky,
   output logic              exc_req,
   output logic              res_wr
);
   logic write_en;

   always_comb write_en = strobe && !suppress;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags      <= '0;
         pmask      <= '0;
         inv_sticky <= 1'b0;
         exc_req    <= 1'b0;
         res_wr     <= 1'b0;
      end else begin
         exc_req <= strobe && suppress;
         res_wr  <= write_en;
         if (write_en && pred_mode == MODE_FLAGS) flags <= flags_nx;
         if (write_en && pred_mode == MODE_PRED)  pmask <= mask_nx;
         if (strobe && invalid)  inv_sticky <= 1'b1;
         else if (sticky_clr)    inv_sticky <= 1'b0;
      end
   end
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
   import fpc_pkg::*;
#(
   parameter int SP_EXP  = 8,
   parameter int SP_FRAC = 23,
   parameter int DP_EXP  = 11,
   parameter int DP_FRAC = 52
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              is_dbl,
   input  logic              pred_mode,
   input  logic              quiet_cmp,
   input  logic              pred_le,
   input  logic              inv_mask,
   input  logic              sticky_clr,
   input  logic [63:0]       opa,
   input  logic [63:0]       opb,
   output logic [5:0]        flags,
   output logic [63:0]       pmask,
   output logic              inv_sticky,
   output logic              exc_req,
   output logic              res_wr
);
   localparam int SP_W = SP_EXP + SP_FRAC + 1;
   localparam int DP_W = DP_EXP + DP_FRAC + 1;
   localparam int N_PREC = 2;

   initial begin
      assert (SP_W == 32) else $error("single precision must be 32 bits wide");
      assert (DP_W == 64) else $error("double precision must be 64 bits wide");
      assert (DP_EXP > SP_EXP) else $error("double exponent must exceed single");
   end

   fpc_class_t cls_a [N_PREC];
   fpc_class_t cls_b [N_PREC];
   logic [N_PREC-1:0] lt_v, eq_v;

   for (genvar p = 0; p < N_PREC; p++) begin : g_prec
      localparam int EW = (p == 0) ? SP_EXP  : DP_EXP;
      localparam int FW = (p == 0) ? SP_FRAC : DP_FRAC;
      localparam int WW = EW + FW + 1;

      fpc_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls_a (
         .val (opa[WW-1:0]),
         .cls (cls_a[p])
      );
      fpc_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls_b (
         .val (opb[WW-1:0]),
         .cls (cls_b[p])
      );
      fpc_order #(.W(WW)) u_ord (
         .a      (opa[WW-1:0]),
         .b      (opb[WW-1:0]),
         .a_zero (cls_a[p].zero),
         .b_zero (cls_b[p].zero),
         .lt     (lt_v[p]),
         .eq     (eq_v[p])
      );
   end

   fpc_class_t ca, cb;
   logic lt, eq, unord, any_snan, invalid, suppress, pred_true;
   logic [FLAG_W-1:0] flags_nx;
   logic [DP_W-1:0]   mask_nx;

   always_comb begin
      ca       = cls_a[is_dbl];
      cb       = cls_b[is_dbl];
      lt       = lt_v[is_dbl];
      eq       = eq_v[is_dbl];
      unord    = ca.nan | cb.nan;
      any_snan = ca.snan | cb.snan;

      if (pred_mode == MODE_PRED) invalid = unord;
      else                        invalid = quiet_cmp ? any_snan : unord;
      suppress = invalid & ~inv_mask;

      if (unord)   flags_nx = FL_UNORD;
      else if (eq) flags_nx = FL_EQ;
      else if (lt) flags_nx = FL_LT;
      else         flags_nx = FL_GT;

      pred_true = unord | (pred_le ? !(lt | eq) : !lt);
      if (!pred_true)  mask_nx = '0;
      else if (is_dbl) mask_nx = '1;
      else             mask_nx = {{(DP_W-SP_W){1'b0}}, {SP_W{1'b1}}};
   end

   fpc_out_reg #(.MASK_W(DP_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (in_valid),
      .pred_mode  (pred_mode),
      .invalid    (invalid),
      .suppress   (suppress),
      .sticky_clr (sticky_clr),
      .flags_nx   (flags_nx),
      .mask_nx    (mask_nx),
      .flags      (flags),
      .pmask      (pmask),
      .inv_sticky (inv_sticky),
      .exc_req    (exc_req),
      .res_wr     (res_wr)
   );
endmodule

// File: rtl/fp_cmp_unit_chk.sv
module fp_cmp_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        sticky_clr,
   input logic [5:0]  flags,
   input logic [63:0] pmask,
   input logic        inv_sticky,
   input logic        exc_req,
   input logic        res_wr
);
   // R5
   suppress_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> ($stable(flags) && $stable(pmask)));
   // R5
   exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(exc_req && res_wr));
   // R10
   exc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> inv_sticky);
   // R10
   sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inv_sticky) |-> $past(sticky_clr));
   // R2
   flag_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[5:3] == 3'b000);
   // R1
   flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[2:0] inside {3'b111, 3'b100, 3'b001, 3'b000});
   // R6
   mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pmask inside {64'h0, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF});
   // R9
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> (!res_wr && !exc_req));
endmodule

bind fp_cmp_unit fp_cmp_unit_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .sticky_clr (sticky_clr),
   .flags      (flags),
   .pmask      (pmask),
   .inv_sticky (inv_sticky),
   .exc_req    (exc_req),
   .res_wr     (res_wr)
);

// File: tb/fp_cmp_unit_test.sv
module fp_cmp_unit_test;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic        dbl, pm, qc, ple, im;
      logic [63:0] a, b;
      logic [5:0]  fl;
      logic [63:0] mk;
      logic        inv, exc;
   } vec_t;

   localparam logic [63:0] S1 = 64'h3F80_0000, S2 = 64'h4000_0000, SM1 = 64'hBF80_0000;
   localparam logic [63:0] SPZ = 64'h0, SNZ = 64'h8000_0000, SQN = 64'h7FC0_0000;
   localparam logic [63:0] SSN = 64'h7FA0_0000, SINF = 64'h7F80_0000;
   localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000, D2 = 64'h4000_0000_0000_0000;
   localparam logic [63:0] DM2 = 64'hC000_0000_0000_0000, DQN = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] DSN = 64'h7FF4_0000_0000_0000;
   localparam logic [63:0] MS = 64'h0000_0000_FFFF_FFFF, MD = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam int NV = 27;

   // fields: dbl pm qc ple im a b fl mk inv exc
   localparam vec_t TBL [NV] = '{
      '{0,0,0,0,1, S1,  S2,  6'h01, 0,  0,0},   // R2 less
      '{0,0,0,0,1, S2,  S1,  6'h00, 0,  0,0},   // R2 greater
      '{0,0,0,0,1, S1,  S1,  6'h04, 0,  0,0},   // R2 equal
      '{0,0,0,0,1, SPZ, SNZ, 6'h04, 0,  0,0},   // R2 signed zeros
      '{0,0,0,0,1, SM1, S1,  6'h01, 0,  0,0},   // R2 negative
      '{0,0,0,0,0, SQN, S1,  6'h07, 0,  1,1},   // R3 R5 qnan signalling
      '{0,0,1,0,0, S1,  SQN, 6'h07, 0,  0,0},   // R4 qnan quiet written
      '{0,0,1,0,0, SSN, S1,  6'h07, 0,  1,1},   // R4 R5 snan quiet
      '{0,0,0,0,1, S2,  S1,  6'h00, 0,  0,0},   // R2
      '{0,0,1,0,1, S1,  SSN, 6'h07, 0,  1,0},   // R1 masked snan
      '{1,0,0,0,1, DM2, D1,  6'h01, 0,  0,0},   // R8 double less
      '{1,0,0,0,1, D2,  D2,  6'h04, 0,  0,0},   // R8 double equal
      '{1,0,1,0,0, D1,  DQN, 6'h07, 0,  0,0},   // R4 R8 double qnan
      '{0,0,0,0,1, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_4000_0000, 6'h01, 0, 0,0}, // R8 upper ignored
      '{0,1,0,0,1, S2,  S1,  0, MS, 0,0},       // R6 NLT true
      '{0,1,0,0,1, S1,  S2,  0, 0,  0,0},       // R6 NLT false
      '{0,1,0,0,1, S1,  S1,  0, MS, 0,0},       // R6 NLT equal
      '{0,1,0,1,1, S1,  S1,  0, 0,  0,0},       // R6 NLE equal
      '{0,1,0,1,1, S2,  S1,  0, MS, 0,0},       // R6 NLE greater
      '{0,1,0,1,1, SQN, S1,  0, MS, 1,0},       // R6 R7 masked nan
      '{0,1,0,0,0, S1,  SQN, 0, 0,  1,1},       // R7 suppressed
      '{0,1,0,0,1, S1,  S2,  0, 0,  0,0},       // R6
      '{1,1,0,0,0, DSN, D1,  0, 0,  1,1},       // R7 double suppressed
      '{1,1,0,1,1, D1,  DQN, 0, MD, 1,0},       // R6 double nan
      '{1,1,0,0,1, D1,  D2,  0, 0,  0,0},       // R6 double false
      '{1,1,0,1,1, D2,  D1,  0, MD, 0,0},       // R6 double true
      '{0,0,0,0,1, SINF, S1, 6'h00, 0, 0,0}     // R2 infinity ordered
   };

   logic clk = 0, rst_n = 0, in_valid = 0, is_dbl = 0, pred_mode = 0;
   logic quiet_cmp = 0, pred_le = 0, inv_mask = 1, sticky_clr = 0;
   logic [63:0] opa = 0, opb = 0;
   logic [5:0]  flags;
   logic [63:0] pmask;
   logic inv_sticky, exc_req, res_wr;
   int n_run = 0, n_fail = 0;
   logic [5:0]  e_fl = 0;
   logic [63:0] e_mk = 0;
   logic        e_st = 0;

   always #(CLK_P/2) clk = ~clk;

   fp_cmp_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_dbl(is_dbl),
      .pred_mode(pred_mode), .quiet_cmp(quiet_cmp), .pred_le(pred_le),
      .inv_mask(inv_mask), .sticky_clr(sticky_clr), .opa(opa), .opb(opb),
      .flags(flags), .pmask(pmask), .inv_sticky(inv_sticky),
      .exc_req(exc_req), .res_wr(res_wr)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic strobe(input vec_t v, input logic clr);
      @(negedge clk);
      is_dbl = v.dbl; pred_mode = v.pm; quiet_cmp = v.qc; pred_le = v.ple;
      inv_mask = v.im; opa = v.a; opb = v.b; sticky_clr = clr; in_valid = 1;
      @(negedge clk);
      in_valid = 0; sticky_clr = 0;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 flags", {58'b0, flags}, 0);
      check("R11 pmask", pmask, 0);
      check("R11 sticky/exc/wr", {61'b0, inv_sticky, exc_req, res_wr}, 0);
      rst_n = 1;

      for (int i = 0; i < NV; i++) begin
         vec_t v = TBL[i];
         strobe(v, 1'b0);
         if (!v.exc) begin
            if (v.pm) e_mk = v.mk;
            else      e_fl = v.fl;
         end
         if (v.inv) e_st = 1;
         check($sformatf("R1 R2 R3 R4 R12 flags vec %0d", i), {58'b0, flags}, {58'b0, e_fl});
         check($sformatf("R6 R7 R12 pmask vec %0d", i), pmask, e_mk);
         check($sformatf("R5 R9 exc/wr vec %0d", i), {62'b0, exc_req, res_wr}, {62'b0, v.exc, !v.exc});
         check($sformatf("R10 sticky vec %0d", i), {63'b0, inv_sticky}, {63'b0, e_st});
      end

      // R9: no strobe, outputs hold and pulses drop
      repeat (3) @(negedge clk);
      check("R9 hold flags", {58'b0, flags}, {58'b0, e_fl});
      check("R9 hold pmask", pmask, e_mk);
      check("R9 no pulses", {62'b0, exc_req, res_wr}, 0);

      // R10: clear alone drops sticky
      @(negedge clk); sticky_clr = 1;
      @(negedge clk); sticky_clr = 0;
      check("R10 clear", {63'b0, inv_sticky}, 0);

      // R10: clear with new invalid in same cycle, set wins
      strobe('{0,0,0,0,1, SQN, S1, 6'h07, 0, 1, 0}, 1'b1);
      check("R10 set beats clear", {63'b0, inv_sticky}, 1);
      check("R1 masked qnan flags", {58'b0, flags}, 64'h07);

      // R10: clear with valid but no invalid clears
      strobe('{0,0,0,0,1, S1, S2, 6'h01, 0, 0, 0}, 1'b1);
      check("R10 clear with ordered", {63'b0, inv_sticky}, 0);
      check("R2 after clear", {58'b0, flags}, 64'h01);

      // R11: reset mid-run
      @(negedge clk); rst_n = 0;
      @(negedge clk);
      check("R11 reset flags", {58'b0, flags}, 0);
      check("R11 reset pmask", pmask, 0);
      rst_n = 1;

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule